// File: doc/BRIEF.md
# Sub-word Store Merge Unit

This block sits between a processor store port and a word-organized memory. The memory can only be written as whole 32-bit words, and every word is stored with error-correcting check bits. Each store is narrowed to one aligned word, and a single register line of eight words holds the store data. An aligned full-word store goes straight into the line and needs no memory read. A byte or halfword store into a word the line does not yet hold starts a read-modify-write. The unit reads the codeword, corrects a single flipped bit, shifts and masks the new bytes in, and keeps the merged word in the line.

Later narrow stores to a word the line already holds merge in place with no further memory access, so many small stores end up as one full-word commit. The unit keeps one dirty bit per word. A write-back, started on request or forced when a store goes to a different line, encodes and writes only the dirty words. Clean words in memory are never touched.

The store port follows valid/ready rules. A store is taken on a clock edge where both `st_valid` and `st_ready` are high. While the unit is busy reading, merging or writing back, `st_ready` is low and the held store must stay stable. Memory reads have one cycle of latency.

Top module: `store_merge_unit`

## Requirements
- R1: After reset `st_ready` is high, no memory read or write is issued, both error flags are low, and no word is dirty, so a write-back right after reset writes nothing.
- R2: Byte address bits [1:0] place the data. A byte store (`st_size`=0) writes `st_data[7:0]` into byte lane `addr[1:0]`. A halfword store (`st_size`=1) writes `st_data[15:0]` into lanes 0–1 when `addr[1]`=0 and into lanes 2–3 when `addr[1]`=1, ignoring `addr[0]`. A word store (`st_size`=2 or 3) writes all 32 bits and ignores `addr[1:0]`. Unselected bytes keep their prior value.
- R3: A word store to the current line, or to any line when no word is dirty, needs no memory read, and `st_ready` is high again in the cycle after acceptance.
- R4: A narrow store to a word the line does not hold reads the aligned word exactly once, with `mem_rd_en` in the cycle after acceptance. `st_ready` stays low for two cycles.
- R5: A narrow store to a word the line already holds merges without any memory read, and `st_ready` stays high.
- R6: Each stored codeword has 39 bits. Bit 0 makes the overall parity of all 39 bits even. Bits 1, 2, 4, 8, 16 and 32 are check bits. The data bits fill the remaining positions 3..38 in ascending order, LSB first. The check bit at position 2^k is the XOR of all other positions whose index has bit k set.
- R7: A single-bit error in the read codeword is corrected before the merge, and `err_corr` pulses for one cycle, two cycles after `mem_rd_en`.
- R8: A double-bit error pulses `err_uncorr` instead. The store is dropped: the word is not marked dirty and memory keeps its old codeword.
- R9: A write-back visits word slots 0 to 7 in order, one per cycle, for eight cycles. It writes only the dirty ones, at word address {line, slot}. `flush_done` pulses in the cycle after the last slot, and all dirty bits are then clear.
- R10: A store to a different line while words are dirty first writes back the old line (eight cycles) and then performs the store. A narrow store then holds `st_ready` low for ten cycles.
- R11: `flush_req` wins over a pending store. `st_ready` is low whenever `flush_req` is high and during any write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request valid |
| st_ready | output | 1 | Store request accepted when high with valid |
| st_addr | input | 10 | Byte address of the store |
| st_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| st_data | input | 32 | Store data, low-aligned |
| flush_req | input | 1 | Request write-back of dirty words |
| flush_done | output | 1 | One-cycle pulse at write-back end |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | 8 | Memory word address for read |
| mem_rd_data | input | 39 | Codeword returned one cycle after read |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | 8 | Memory word address for write |
| mem_wr_data | output | 39 | Codeword to write |
| err_corr | output | 1 | Pulse: single-bit error corrected |
| err_uncorr | output | 1 | Pulse: double-bit error, store dropped |

## Verification
Relative to the acceptance edge, a full or hit store frees the port in the next cycle. A narrow miss shows `mem_rd_en` one cycle later, returns ready and raises any error flag three cycles later, and an eviction adds eight cycles to these. After the request edge, a write-back lasts eight cycles, with `flush_done` in the ninth. The bench drives inputs on the falling edge and counts falling edges from the accepting edge until ready or done. It compares those counts with the fixed figures above, samples the error flags in the very cycle ready returns, and checks memory contents only after `flush_done`.

// File: rtl/smu_pkg.sv
package smu_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_CHECK, ST_WRITE} smu_state_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  // Hamming layout: positions that are powers of two carry check bits.
  function automatic bit is_check_pos(input int p);
    return (p & (p - 1)) == 0;
  endfunction
endpackage

// File: rtl/smu_ecc_enc.sv
module smu_ecc_enc
  import smu_pkg::*;
#(
  parameter int DW = 32,
  parameter int PB = 6,
  localparam int CW = DW + PB + 1
) (
  input  logic [DW-1:0] data_i,
  output logic [CW-1:0] code_o
);
  always_comb begin
    logic [CW-1:0] c;
    logic par;
    int n;
    c = '0;
    n = 0;
    for (int p = 1; p < CW; p++) begin
      if (!is_check_pos(p)) begin
        c[p] = data_i[n];
        n++;
      end
    end
    for (int k = 0; k < PB; k++) begin
      par = 1'b0;
      for (int p = 1; p < CW; p++) begin
        if (((p >> k) & 1) == 1 && !is_check_pos(p)) par = par ^ c[p];
      end
      c[1 << k] = par;
    end
    c[0] = ^c[CW-1:1];
    code_o = c;
  end
endmodule

// File: rtl/smu_ecc_dec.sv
module smu_ecc_dec
  import smu_pkg::*;
#(
  parameter int DW = 32,
  parameter int PB = 6,
  localparam int CW = DW + PB + 1
) (
  input  logic [CW-1:0] code_i,
  output logic [DW-1:0] data_o,
  output logic          single_o,
  output logic          double_o
);
  always_comb begin
    logic [PB-1:0] syn;
    logic [CW-1:0] f;
    int n;
    syn = '0;
    single_o = 1'b0;
    double_o = 1'b0;
    for (int p = 1; p < CW; p++) begin
      if (code_i[p]) syn = syn ^ PB'(p);
    end
    f = code_i;
    if (^code_i) begin
      if (int'(syn) < CW) begin
        f[syn] = ~f[syn];
        single_o = 1'b1;
      end else begin
        double_o = 1'b1;
      end
    end else if (syn != '0) begin
      double_o = 1'b1;
    end
    data_o = '0;
    n = 0;
    for (int p = 1; p < CW; p++) begin
      if (!is_check_pos(p)) begin
        data_o[n] = f[p];
        n++;
      end
    end
  end
endmodule

// File: rtl/smu_byte_merge.sv
module smu_byte_merge
  import smu_pkg::*;
#(
  parameter int DW = 32,
  localparam int NB = DW / 8,
  localparam int OW = $clog2(NB)
) (
  input  logic [DW-1:0] base_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [1:0]    size_i,
  input  logic [OW-1:0] off_i,
  output logic [DW-1:0] merged_o,
  output logic [NB-1:0] be_o
);
  logic [OW-1:0] lane;
  logic [DW-1:0] narrowed;
  logic [DW-1:0] shifted;

  always_comb begin
    case (size_i)
      SZ_BYTE: begin
        lane     = off_i;
        narrowed = DW'(wdata_i[7:0]);
        be_o     = NB'(1) << off_i;
      end
      SZ_HALF: begin
        lane     = {off_i[OW-1:1], 1'b0};
        narrowed = DW'(wdata_i[15:0]);
        be_o     = NB'(3) << {off_i[OW-1:1], 1'b0};
      end
      default: begin
        lane     = '0;
        narrowed = wdata_i;
        be_o     = '1;
      end
    endcase
    shifted = narrowed << {lane, 3'b000};
  end

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign merged_o[8*g +: 8] = be_o[g] ? shifted[8*g +: 8] : base_i[8*g +: 8];
  end
endmodule

// File: rtl/store_merge_unit.sv
module store_merge_unit
  import smu_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int PB = 6,
  parameter int LW = 8,
  localparam int CW = DW + PB + 1,
  localparam int OW = $clog2(DW / 8),
  localparam int IW = $clog2(LW),
  localparam int TW = AW - IW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_valid,
  output logic          st_ready,
  input  logic [AW+OW-1:0] st_addr,
  input  logic [1:0]    st_size,
  input  logic [DW-1:0] st_data,
  input  logic          flush_req,
  output logic          flush_done,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_rd_addr,
  input  logic [CW-1:0] mem_rd_data,
  output logic          mem_wr_en,
  output logic [AW-1:0] mem_wr_addr,
  output logic [CW-1:0] mem_wr_data,
  output logic          err_corr,
  output logic          err_uncorr
);
  smu_state_e    state_q;
  logic [TW-1:0] tag_q;
  logic [DW-1:0] line_q [LW];
  logic [LW-1:0] valid_q, dirty_q;
  logic [IW-1:0] idx_q;
  logic          from_flush_q;
  logic [TW-1:0] req_tag_q;
  logic [IW-1:0] req_idx_q;
  logic [OW-1:0] req_off_q;
  logic [1:0]    req_size_q;
  logic [DW-1:0] req_data_q;
  logic          flush_done_q, err_corr_q, err_uncorr_q;

  // Incoming address split
  logic [TW-1:0] a_tag;
  logic [IW-1:0] a_idx;
  logic [OW-1:0] a_off;
  assign a_tag = st_addr[AW+OW-1:OW+IW];
  assign a_idx = st_addr[OW+IW-1:OW];
  assign a_off = st_addr[OW-1:0];

  logic in_idle, accept, hit_line;
  assign in_idle  = (state_q == ST_IDLE);
  assign st_ready = in_idle && !flush_req;
  assign accept   = st_valid && st_ready;
  assign hit_line = (a_tag == tag_q);

  // Shared merge datapath: port fields in idle, held request otherwise
  logic [IW-1:0]   cur_idx;
  logic [OW-1:0]   cur_off;
  logic [1:0]      cur_size;
  logic [DW-1:0]   cur_data, base, merged, dec_data;
  logic [DW/8-1:0] be;
  logic            full, dec_single, dec_double;

  assign cur_idx  = in_idle ? a_idx   : req_idx_q;
  assign cur_off  = in_idle ? a_off   : req_off_q;
  assign cur_size = in_idle ? st_size : req_size_q;
  assign cur_data = in_idle ? st_data : req_data_q;
  assign base     = (state_q == ST_CHECK) ? dec_data : line_q[cur_idx];
  assign full     = &be;

  smu_byte_merge #(.DW(DW)) u_merge (
    .base_i(base), .wdata_i(cur_data), .size_i(cur_size), .off_i(cur_off),
    .merged_o(merged), .be_o(be)
  );

  smu_ecc_dec #(.DW(DW), .PB(PB)) u_dec (
    .code_i(mem_rd_data), .data_o(dec_data),
    .single_o(dec_single), .double_o(dec_double)
  );

  smu_ecc_enc #(.DW(DW), .PB(PB)) u_enc (
    .data_i(line_q[idx_q]), .code_o(mem_wr_data)
  );

  assign mem_rd_en   = (state_q == ST_READ);
  assign mem_rd_addr = {tag_q, req_idx_q};
  assign mem_wr_en   = (state_q == ST_WRITE) && dirty_q[idx_q];
  assign mem_wr_addr = {tag_q, idx_q};
  assign flush_done  = flush_done_q;
  assign err_corr    = err_corr_q;
  assign err_uncorr  = err_uncorr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      tag_q        <= '0;
      line_q       <= '{default: '0};
      valid_q      <= '0;
      dirty_q      <= '0;
      idx_q        <= '0;
      from_flush_q <= 1'b0;
      req_tag_q    <= '0;
      req_idx_q    <= '0;
      req_off_q    <= '0;
      req_size_q   <= '0;
      req_data_q   <= '0;
      flush_done_q <= 1'b0;
      err_corr_q   <= 1'b0;
      err_uncorr_q <= 1'b0;
    end else begin
      flush_done_q <= 1'b0;
      err_corr_q   <= 1'b0;
      err_uncorr_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            req_tag_q  <= a_tag;
            req_idx_q  <= a_idx;
            req_off_q  <= a_off;
            req_size_q <= st_size;
            req_data_q <= st_data;
            if (!hit_line && (|dirty_q)) begin
              state_q      <= ST_WRITE;
              idx_q        <= '0;
              from_flush_q <= 1'b0;
            end else begin
              if (!hit_line) begin
                tag_q   <= a_tag;
                valid_q <= '0;
              end
              if (full || (hit_line && valid_q[a_idx])) begin
                line_q[a_idx]  <= merged;
                valid_q[a_idx] <= 1'b1;
                dirty_q[a_idx] <= 1'b1;
              end else begin
                state_q <= ST_READ;
              end
            end
          end else if (flush_req) begin
            state_q      <= ST_WRITE;
            idx_q        <= '0;
            from_flush_q <= 1'b1;
          end
        end
        ST_READ: state_q <= ST_CHECK;
        ST_CHECK: begin
          state_q <= ST_IDLE;
          if (dec_double) begin
            err_uncorr_q <= 1'b1;
          end else begin
            line_q[req_idx_q]  <= merged;
            valid_q[req_idx_q] <= 1'b1;
            dirty_q[req_idx_q] <= 1'b1;
            err_corr_q         <= dec_single;
          end
        end
        ST_WRITE: begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == IW'(LW - 1)) begin
            dirty_q <= '0;
            if (from_flush_q) begin
              flush_done_q <= 1'b1;
              state_q      <= ST_IDLE;
            end else begin
              tag_q   <= req_tag_q;
              valid_q <= '0;
              if (full) begin
                line_q[req_idx_q]  <= merged;
                valid_q[req_idx_q] <= 1'b1;
                dirty_q[req_idx_q] <= 1'b1;
                state_q            <= ST_IDLE;
              end else begin
                state_q <= ST_READ;
              end
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/smu_checks.sv
module smu_checks #(
  parameter int AW = 8,
  parameter int CW = 39
) (
  input logic          clk,
  input logic          rst_n,
  input logic          st_ready,
  input logic          flush_req,
  input logic          flush_done,
  input logic          mem_rd_en,
  input logic          mem_wr_en,
  input logic [CW-1:0] mem_wr_data,
  input logic          err_corr,
  input logic          err_uncorr
);
  assert_rd_stalls_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> !st_ready);
  assert_single_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);
  assert_wr_even_parity_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> (^mem_wr_data) == 1'b0);
  assert_corr_timing_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_corr |-> $past(mem_rd_en, 2));
  assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_corr && err_uncorr));
  assert_no_rd_during_wr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en));
  assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |-> (!mem_wr_en && !mem_rd_en));
  assert_busy_on_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en || flush_req) |-> !st_ready);
endmodule

bind store_merge_unit smu_checks #(.AW(AW), .CW(CW)) u_checks (
  .clk(clk), .rst_n(rst_n), .st_ready(st_ready), .flush_req(flush_req),
  .flush_done(flush_done), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
  .mem_wr_data(mem_wr_data), .err_corr(err_corr), .err_uncorr(err_uncorr)
);

// File: tb/store_merge_unit_test.sv
`timescale 1ns/1ps
module store_merge_unit_test;
  localparam int AW = 8;
  localparam int CW = 39;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          st_valid = 1'b0;
  logic          st_ready;
  logic [AW+1:0] st_addr = '0;
  logic [1:0]    st_size = '0;
  logic [31:0]   st_data = '0;
  logic          flush_req = 1'b0;
  logic          flush_done;
  logic          mem_rd_en, mem_wr_en;
  logic [AW-1:0] mem_rd_addr, mem_wr_addr;
  logic [CW-1:0] mem_rd_data = '0;
  logic [CW-1:0] mem_wr_data;
  logic          err_corr, err_uncorr;

  logic [CW-1:0] mem [0:(1<<AW)-1];
  int rd_count = 0;
  int wr_count = 0;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  store_merge_unit uut (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_size(st_size), .st_data(st_data),
    .flush_req(flush_req), .flush_done(flush_done),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .err_corr(err_corr), .err_uncorr(err_uncorr)
  );

  // Memory model: registered read, one cycle latency
  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rd_data <= mem[mem_rd_addr];
      rd_count <= rd_count + 1;
    end
    if (mem_wr_en) begin
      mem[mem_wr_addr] <= mem_wr_data;
      wr_count <= wr_count + 1;
    end
  end

  function automatic logic [CW-1:0] ref_enc(input logic [31:0] d);
    logic [CW-1:0] c;
    int n;
    c = '0;
    n = 0;
    for (int p = 1; p < CW; p++)
      if ((p & (p - 1)) != 0) begin c[p] = d[n]; n++; end
    for (int k = 0; k < 6; k++)
      for (int p = 3; p < CW; p++)
        if ((p & (p - 1)) != 0 && ((p >> k) & 1) == 1) c[1 << k] = c[1 << k] ^ c[p];
    c[0] = ^c[CW-1:1];
    return c;
  endfunction

  function automatic logic [AW+1:0] baddr(input int line, input int word, input int off);
    return {line[4:0], word[2:0], off[1:0]};
  endfunction

  function automatic logic [AW-1:0] waddr(input int line, input int word);
    return {line[4:0], word[2:0]};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_store(input logic [AW+1:0] a, input logic [1:0] sz, input logic [31:0] d,
                          output int busy, output logic ec, output logic eu, output int rds);
    int rd0;
    int guard;
    rd0 = rd_count;
    @(negedge clk);
    st_addr = a; st_size = sz; st_data = d; st_valid = 1'b1;
    guard = 0;
    while (!st_ready && guard < 100) begin @(negedge clk); guard++; end
    @(posedge clk);
    @(negedge clk);
    st_valid = 1'b0;
    busy = 0;
    while (!st_ready && busy < 100) begin busy++; @(negedge clk); end
    ec = err_corr;
    eu = err_uncorr;
    rds = rd_count - rd0;
  endtask

  task automatic do_flush(output int cyc, output int wrs);
    int w0;
    w0 = wr_count;
    @(negedge clk);
    flush_req = 1'b1;
    @(posedge clk);
    @(negedge clk);
    flush_req = 1'b0;
    cyc = 1;
    while (!flush_done && cyc < 50) begin @(negedge clk); cyc++; end
    wrs = wr_count - w0;
  endtask

  task automatic t_reset;
    int cyc, wrs;
    check(st_ready == 1'b1, "R1", "st_ready after reset", st_ready, 1);
    check(!mem_rd_en && !mem_wr_en, "R1", "memory idle after reset", {mem_rd_en, mem_wr_en}, 0);
    check(!err_corr && !err_uncorr, "R1", "error flags after reset", {err_corr, err_uncorr}, 0);
    do_flush(cyc, wrs);
    check(cyc == 9, "R9", "flush length", cyc, 9);
    check(wrs == 0, "R1", "writes of clean line", wrs, 0);
  endtask

  task automatic t_full_store;
    int busy, rds, cyc, wrs;
    logic ec, eu;
    do_store(baddr(1, 2, 0), 2'd2, 32'hCAFEF00D, busy, ec, eu, rds);
    check(busy == 0, "R3", "full store busy", busy, 0);
    check(rds == 0, "R3", "full store reads", rds, 0);
    do_flush(cyc, wrs);
    check(wrs == 1, "R9", "dirty word writes", wrs, 1);
    check(mem[waddr(1, 2)] == ref_enc(32'hCAFEF00D), "R6", "full word codeword",
          mem[waddr(1, 2)], ref_enc(32'hCAFEF00D));
  endtask

  task automatic t_narrow_merge;
    int busy, rds, cyc, wrs;
    logic ec, eu;
    mem[waddr(2, 5)] = ref_enc(32'h11223344);
    mem[waddr(2, 6)] = ref_enc(32'h55667788);
    do_store(baddr(2, 5, 1), 2'd0, 32'hFFFFFFAB, busy, ec, eu, rds);
    check(busy == 2, "R4", "narrow miss busy", busy, 2);
    check(rds == 1, "R4", "narrow miss reads", rds, 1);
    check(!ec && !eu, "R4", "clean read flags", {ec, eu}, 0);
    do_store(baddr(2, 5, 3), 2'd0, 32'h000000CD, busy, ec, eu, rds);
    check(busy == 0 && rds == 0, "R5", "narrow hit busy/reads", {busy[15:0], rds[15:0]}, 0);
    do_store(baddr(2, 5, 3), 2'd1, 32'h1234BEEF, busy, ec, eu, rds);
    check(busy == 0 && rds == 0, "R5", "half hit busy/reads", {busy[15:0], rds[15:0]}, 0);
    do_flush(cyc, wrs);
    check(wrs == 1, "R9", "one merged commit", wrs, 1);
    check(mem[waddr(2, 5)] == ref_enc(32'hBEEFAB44), "R2", "merged lanes",
          mem[waddr(2, 5)], ref_enc(32'hBEEFAB44));
    check(mem[waddr(2, 6)] == ref_enc(32'h55667788), "R9", "clean neighbour untouched",
          mem[waddr(2, 6)], ref_enc(32'h55667788));
  endtask

  task automatic t_single_error;
    int busy, rds, cyc, wrs;
    logic ec, eu;
    mem[waddr(3, 0)] = ref_enc(32'hDEADBEEF) ^ (39'd1 << 9);
    do_store(baddr(3, 0, 0), 2'd0, 32'h00000000, busy, ec, eu, rds);
    check(ec == 1'b1 && eu == 1'b0, "R7", "corrected flag", {ec, eu}, 2'b10);
    check(busy == 2, "R7", "busy with correction", busy, 2);
    do_flush(cyc, wrs);
    check(mem[waddr(3, 0)] == ref_enc(32'hDEADBE00), "R7", "corrected merge",
          mem[waddr(3, 0)], ref_enc(32'hDEADBE00));
  endtask

  task automatic t_double_error;
    int busy, rds, cyc, wrs;
    logic ec, eu;
    logic [CW-1:0] bad;
    bad = ref_enc(32'h0F0F0F0F) ^ (39'd1 << 3) ^ (39'd1 << 20);
    mem[waddr(4, 1)] = bad;
    do_store(baddr(4, 1, 0), 2'd1, 32'h00001111, busy, ec, eu, rds);
    check(eu == 1'b1 && ec == 1'b0, "R8", "uncorrectable flag", {ec, eu}, 2'b01);
    do_flush(cyc, wrs);
    check(wrs == 0, "R8", "dropped store writes", wrs, 0);
    check(mem[waddr(4, 1)] == bad, "R8", "memory unchanged", mem[waddr(4, 1)], bad);
  endtask

  task automatic t_evict;
    int busy, rds, cyc, wrs;
    logic ec, eu;
    int w0;
    mem[waddr(6, 0)] = ref_enc(32'h01020304);
    do_store(baddr(5, 7, 0), 2'd2, 32'h77777777, busy, ec, eu, rds);
    w0 = wr_count;
    do_store(baddr(6, 0, 0), 2'd0, 32'h00000099, busy, ec, eu, rds);
    check(busy == 10, "R10", "evict then RMW busy", busy, 10);
    check(rds == 1, "R10", "reads after evict", rds, 1);
    check(wr_count - w0 == 1, "R10", "evict writes", wr_count - w0, 1);
    check(mem[waddr(5, 7)] == ref_enc(32'h77777777), "R10", "evicted word",
          mem[waddr(5, 7)], ref_enc(32'h77777777));
    do_flush(cyc, wrs);
    check(mem[waddr(6, 0)] == ref_enc(32'h01020399), "R10", "new line word",
          mem[waddr(6, 0)], ref_enc(32'h01020399));
  endtask

  task automatic t_priority;
    int busy, rds, cyc, wrs;
    logic ec, eu;
    do_store(baddr(7, 1, 0), 2'd2, 32'hAAAA0001, busy, ec, eu, rds);
    @(negedge clk);
    st_addr = baddr(7, 1, 0); st_size = 2'd2; st_data = 32'hBBBB0002;
    st_valid = 1'b1; flush_req = 1'b1;
    #1;
    check(st_ready == 1'b0, "R11", "ready with flush_req", st_ready, 0);
    @(posedge clk);
    @(negedge clk);
    flush_req = 1'b0;
    check(st_ready == 1'b0, "R11", "ready during write-back", st_ready, 0);
    cyc = 1;
    while (!flush_done && cyc < 50) begin @(negedge clk); cyc++; end
    check(mem[waddr(7, 1)] == ref_enc(32'hAAAA0001), "R11", "flush wrote old data",
          mem[waddr(7, 1)], ref_enc(32'hAAAA0001));
    @(posedge clk);
    @(negedge clk);
    st_valid = 1'b0;
    do_flush(cyc, wrs);
    check(mem[waddr(7, 1)] == ref_enc(32'hBBBB0002), "R11", "store after flush",
          mem[waddr(7, 1)], ref_enc(32'hBBBB0002));
  endtask

  task automatic t_clean_and_misaligned;
    int busy, rds, cyc, wrs;
    logic ec, eu;
    do_flush(cyc, wrs);
    check(wrs == 0, "R9", "second flush writes", wrs, 0);
    do_store(baddr(1, 3, 2), 2'd2, 32'h12345678, busy, ec, eu, rds);
    check(busy == 0 && rds == 0, "R3", "word store low bits set", {busy[15:0], rds[15:0]}, 0);
    do_flush(cyc, wrs);
    check(mem[waddr(1, 3)] == ref_enc(32'h12345678), "R2", "word ignores addr[1:0]",
          mem[waddr(1, 3)], ref_enc(32'h12345678));
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_store();
    t_narrow_merge();
    t_single_error();
    t_double_error();
    t_evict();
    t_priority();
    t_clean_and_misaligned();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule